// File: doc/BRIEF.md
# Prescaled Watchdog Timer

The block is a memory-mapped watchdog for a larger system. The input clock goes through two scaling stages before it reaches a 16-bit down-counter. The first stage is an 8-bit programmable prescaler. The second is a fixed power-of-two divider chosen by a select field. Each scaled tick decrements the counter by one. When a tick arrives while the counter is already zero, the watchdog expires. On expiry it can raise a fixed-length reset pulse, a one-cycle interrupt pulse, or both, and it then restarts from a separately held reload value.

Firmware keeps the system alive by writing the counter register before it runs out. That write also restarts both scaling stages, so the first tick after it is exactly one full scaled period away. Clearing the run bit freezes the countdown and keeps every programmed value. The block comes out of reset already counting, with the reset output armed, so a system that never starts its software is still recovered.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the control register reads 0x0000FF03, the reload and count registers read 0x8000, and both expiry outputs are low. Control bit 0 is run, bit 1 is reset-enable, bit 2 is interrupt-enable, bits 5:4 are the divider select and bits 15:8 are the prescale value. All other bits read as zero.
- R2: Control is at offset 0x0, reload at 0x4 and count at 0x8, and all three read back on `bus_rdata` in the same cycle. Any other offset reads zero, and a write to it changes no register.
- R3: While running, one tick occurs every (P+1)*D clock cycles. P is the prescale field. D is 16, 32, 64 or 128 for select values 0, 1, 2 and 3.
- R4: Each tick decrements a nonzero count by one. A tick at count zero is an expiry: the count is loaded from the reload register. The count therefore expires once every reload+1 ticks.
- R5: On expiry with interrupt-enable set, `wdt_irq_o` is high for exactly one cycle, in the cycle after the expiring tick. It stays low otherwise.
- R6: On expiry with reset-enable set, `wdt_rst_o` goes high in the cycle after the expiring tick and stays high for RST_LEN cycles (default 8).
- R7: A write to the count register loads the written value, takes priority over a tick in the same cycle, and restarts both scaling stages. The next tick comes exactly (P+1)*D cycles after the write. Regular writes prevent expiry.
- R8: A write to the reload register does not change the running count. The new value is used at the next expiry.
- R9: With run clear, the count holds, no tick or expiry occurs, and the reload and control values are kept.
- R10: Reset and interrupt enables act independently. With both set, both outputs rise in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wdt_rst_o | output | 1 | Expiry reset pulse, RST_LEN cycles |
| wdt_irq_o | output | 1 | Expiry interrupt pulse, one cycle |

## Verification
The main function is exercised with several prescale and divider pairs and short reload values. Measuring the gap between successive interrupts separates prescaler errors from divider-select errors and from off-by-one errors in the count. A keep-alive written during a run, followed by a write of zero, shows whether the scaling stages restart on a counter write. A reload change made mid-run shows whether it leaks into the live count. A disabled period, an unused offset, and runs with reset only, interrupt only and both enabled separate the two expiry paths and the run gate. A behavioural reference model runs alongside the design every cycle and also compares the read data.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int PRE_W         = 8;
  localparam int DSEL_W        = 2;
  localparam int DIV_BASE_LOG2 = 4;
  localparam int DIV_CNT_W     = DIV_BASE_LOG2 + (1 << DSEL_W) - 1;

  localparam int OFS_CTRL   = 'h0;
  localparam int OFS_RELOAD = 'h4;
  localparam int OFS_COUNT  = 'h8;

  // control word bit positions
  localparam int BIT_RUN   = 0;
  localparam int BIT_RSTEN = 1;
  localparam int BIT_IRQEN = 2;
  localparam int LSB_DSEL  = 4;
  localparam int LSB_PRE   = 8;

  typedef struct packed {
    logic [PRE_W-1:0]  presc;
    logic [DSEL_W-1:0] dsel;
    logic              irq_en;
    logic              rst_en;
    logic              run;
  } ctrl_t;

  function automatic logic [31:0] ctrl_pack(input ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[BIT_RUN]                    = c.run;
    w[BIT_RSTEN]                  = c.rst_en;
    w[BIT_IRQEN]                  = c.irq_en;
    w[LSB_DSEL +: DSEL_W]         = c.dsel;
    w[LSB_PRE  +: PRE_W]          = c.presc;
    return w;
  endfunction

  function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
    ctrl_t c;
    c.run    = w[BIT_RUN];
    c.rst_en = w[BIT_RSTEN];
    c.irq_en = w[BIT_IRQEN];
    c.dsel   = w[LSB_DSEL +: DSEL_W];
    c.presc  = w[LSB_PRE  +: PRE_W];
    return c;
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int                CNT_W     = 16,
  parameter int                ADDR_W    = 4,
  parameter int                DATA_W    = 32,
  parameter logic [CNT_W-1:0]  INIT_LOAD = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt_val,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              cnt_wr,
  output logic [CNT_W-1:0]  cnt_wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam ctrl_t CTRL_INIT = '{presc: '1, dsel: '0, irq_en: 1'b0,
                                  rst_en: 1'b1, run: 1'b1};

  logic hit_ctrl, hit_reload, hit_count;
  ctrl_t            ctrl_d;
  logic [CNT_W-1:0] reload_d;
  logic [31:0]      wword;
  logic             unused_wdata_bits;

  assign hit_ctrl   = (addr == ADDR_W'(OFS_CTRL));
  assign hit_reload = (addr == ADDR_W'(OFS_RELOAD));
  assign hit_count  = (addr == ADDR_W'(OFS_COUNT));

  assign wword             = 32'(wdata);
  assign unused_wdata_bits = ^wword;

  // next state
  always_comb begin
    ctrl_d   = ctrl;
    reload_d = reload;
    if (wr_en && hit_ctrl)   ctrl_d   = ctrl_unpack(wword);
    if (wr_en && hit_reload) reload_d = wword[CNT_W-1:0];
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl   <= CTRL_INIT;
      reload <= INIT_LOAD;
    end else begin
      ctrl   <= ctrl_d;
      reload <= reload_d;
    end
  end

  assign cnt_wr    = wr_en && hit_count;
  assign cnt_wdata = wword[CNT_W-1:0];

  // read mux
  always_comb begin
    rdata = '0;
    if (hit_ctrl)   rdata = DATA_W'(ctrl_pack(ctrl));
    if (hit_reload) rdata = DATA_W'(reload);
    if (hit_count)  rdata = DATA_W'(cnt_val);
  end

  AST_RELOAD_WRITE: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && hit_reload) |=> reload == $past(wword[CNT_W-1:0])); // R8
  AST_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && !hit_ctrl && !hit_reload) |=> ($stable(reload) && $stable(ctrl))); // R2

endmodule

// File: rtl/wdog_scaler.sv
module wdog_scaler
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              run,
  input  logic              restart,
  input  logic [PRE_W-1:0]  presc,
  input  logic [DSEL_W-1:0] dsel,
  output logic              tick
);

  logic [PRE_W-1:0]     pre_q, pre_d;
  logic [DIV_CNT_W-1:0] div_q, div_d;
  logic [DIV_CNT_W-1:0] div_term;
  logic                 pre_hit, div_hit;

  // terminal count of the fixed divider for each select value
  assign div_term = DIV_CNT_W'((1 << (DIV_BASE_LOG2 + int'(dsel))) - 1);

  // >= keeps the stages from running past a freshly lowered limit
  assign pre_hit = (pre_q >= presc);
  assign div_hit = (div_q >= div_term);
  assign tick    = run && pre_hit && div_hit;

  always_comb begin
    pre_d = pre_q;
    div_d = div_q;
    if (!run || restart) begin
      pre_d = '0;
      div_d = '0;
    end else if (pre_hit) begin
      pre_d = '0;
      div_d = div_hit ? '0 : div_q + 1'b1;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      div_q <= '0;
    end else begin
      pre_q <= pre_d;
      div_q <= div_d;
    end
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_ni)
    tick |=> !tick); // R3
  AST_RESTART_FULL: assert property (@(posedge clk) disable iff (!rst_ni)
    restart |=> !tick); // R7
  AST_HALT_NO_TICK: assert property (@(posedge clk) disable iff (!rst_ni)
    !run |=> (pre_q == '0 && div_q == '0)); // R9

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int               CNT_W     = 16,
  parameter int               RST_LEN   = 8,
  parameter logic [CNT_W-1:0] INIT_LOAD = 16'h8000
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             tick,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] reload,
  input  logic             rst_en,
  input  logic             irq_en,
  output logic [CNT_W-1:0] cnt,
  output logic             irq_o,
  output logic             rst_o
);

  localparam int RC_W = $clog2(RST_LEN + 1);

  logic [CNT_W-1:0] cnt_d;
  logic [RC_W-1:0]  rc_q, rc_d;
  logic             irq_d;
  logic             expire;

  assign expire = tick && !wr && (cnt == '0);

  always_comb begin
    cnt_d = cnt;
    if (wr)                cnt_d = wdata;
    else if (tick)         cnt_d = (cnt == '0) ? reload : cnt - 1'b1;
  end

  always_comb begin
    irq_d = expire && irq_en;
    rc_d  = rc_q;
    if (expire && rst_en)  rc_d = RC_W'(RST_LEN);
    else if (rc_q != '0)   rc_d = rc_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt   <= INIT_LOAD;
      rc_q  <= '0;
      irq_o <= 1'b0;
    end else begin
      cnt   <= cnt_d;
      rc_q  <= rc_d;
      irq_o <= irq_d;
    end
  end

  assign rst_o = (rc_q != '0);

  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick && !wr && cnt != '0) |=> cnt == $past(cnt) - 1'b1); // R4
  AST_RELOAD_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick && !wr && cnt == '0) |=> cnt == $past(reload)); // R4
  AST_KEEPALIVE_LOAD: assert property (@(posedge clk) disable iff (!rst_ni)
    wr |=> cnt == $past(wdata)); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    (!tick && !wr) |=> $stable(cnt)); // R9
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_o |-> $past(irq_en && tick)); // R5
  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(rst_o) |-> $past(rst_en && tick)); // R6

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int               CNT_W       = 16,
  parameter int               ADDR_W      = 4,
  parameter int               DATA_W      = 32,
  parameter int               RST_LEN     = 8,
  parameter int               SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] INIT_LOAD   = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_rst_o,
  output logic              wdt_irq_o
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   rst_ni;

  generate
    if (SYNC_STAGES > 1) begin : g_sync_chain
      assign sync_d = {sync_q[SYNC_STAGES-2:0], 1'b1};
    end else begin : g_sync_single
      assign sync_d = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ni = sync_q[SYNC_STAGES-1];

  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload, cnt_val, cnt_wdata;
  logic             cnt_wr, tick;

  wdog_regs #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INIT_LOAD(INIT_LOAD)
  ) u_regs (
    .clk(clk), .rst_ni(rst_ni), .wr_en(bus_wr_en), .addr(bus_addr),
    .wdata(bus_wdata), .cnt_val(cnt_val), .ctrl(ctrl), .reload(reload),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .rdata(bus_rdata)
  );

  wdog_scaler u_scaler (
    .clk(clk), .rst_ni(rst_ni), .run(ctrl.run), .restart(cnt_wr),
    .presc(ctrl.presc), .dsel(ctrl.dsel), .tick(tick)
  );

  wdog_counter #(
    .CNT_W(CNT_W), .RST_LEN(RST_LEN), .INIT_LOAD(INIT_LOAD)
  ) u_counter (
    .clk(clk), .rst_ni(rst_ni), .tick(tick), .wr(cnt_wr), .wdata(cnt_wdata),
    .reload(reload), .rst_en(ctrl.rst_en), .irq_en(ctrl.irq_en),
    .cnt(cnt_val), .irq_o(wdt_irq_o), .rst_o(wdt_rst_o)
  );

  AST_NO_EXPIRY_HALTED: assert property (@(posedge clk) disable iff (!rst_ni)
    (!ctrl.run && !wdt_rst_o) |=> !wdt_irq_o); // R9
  AST_BOTH_TOGETHER: assert property (@(posedge clk) disable iff (!rst_ni)
    (wdt_irq_o && ctrl.rst_en && $past(ctrl.rst_en)) |-> $rose(wdt_rst_o) || $past(wdt_rst_o)); // R10

endmodule

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;

  localparam int RLEN = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'h8;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_o, irq_o;

  int n_chk = 0, n_fail = 0, cyc = 0, irq_total = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wdog_timer #(.RST_LEN(RLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(wr_en), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .wdt_rst_o(rst_o), .wdt_irq_o(irq_o)
  );

  // ---------------- behavioural reference ----------------
  int m_sync = 0;
  bit m_run = 1, m_rsten = 1, m_irqen = 0;
  int m_dsel = 0, m_pre = 255, m_rel = 'h8000, m_cnt = 'h8000;
  int m_ph = 0, m_rstc = 0;
  bit m_irq = 0;

  task automatic m_reset();
    m_run = 1; m_rsten = 1; m_irqen = 0; m_dsel = 0; m_pre = 255;
    m_rel = 'h8000; m_cnt = 'h8000; m_ph = 0; m_rstc = 0; m_irq = 0;
  endtask

  function automatic int m_read(input logic [3:0] a);
    case (a)
      4'h0: return (m_pre << 8) | (m_dsel << 4) | (m_irqen << 2) | (m_rsten << 1) | m_run;
      4'h4: return m_rel;
      4'h8: return m_cnt;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sync = 0; m_reset();
    end else if (m_sync < 2) begin
      m_sync++; m_reset();
    end else begin
      int period, ncnt;
      bit tk, cw, exp;
      period = (m_pre + 1) * (16 << m_dsel);
      cw  = wr_en && addr == 4'h8;
      tk  = m_run && (m_ph == period - 1);
      exp = tk && !cw && m_cnt == 0;
      ncnt = cw ? int'(wdata[15:0]) : (tk ? (m_cnt == 0 ? m_rel : m_cnt - 1) : m_cnt);
      m_ph = (!m_run || cw || tk) ? 0 : m_ph + 1;
      if (exp && m_rsten) m_rstc = RLEN; else if (m_rstc > 0) m_rstc--;
      m_irq = exp && m_irqen;
      m_cnt = ncnt;
      if (wr_en && addr == 4'h0) begin
        m_run = wdata[0]; m_rsten = wdata[1]; m_irqen = wdata[2];
        m_dsel = int'(wdata[5:4]); m_pre = int'(wdata[15:8]);
      end
      if (wr_en && addr == 4'h4) m_rel = int'(wdata[15:0]);
    end
  end

  // ---------------- checks ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the edge
  always @(posedge clk) begin
    #1;
    cyc++;
    if (irq_o) irq_total++;
    if (cyc > 3 && !done) begin
      chk(irq_o === m_irq, "R5", "irq", int'(irq_o), int'(m_irq));
      chk(rst_o === (m_rstc != 0), "R6", "rst", int'(rst_o), int'(m_rstc != 0));
      chk(rdata === 32'(m_read(addr)), addr == 4'h8 ? "R4" : "R2", "rdata",
          int'(rdata), m_read(addr));
    end
  end

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; addr = 4'h8;
  endtask

  task automatic bus_rd(input logic [3:0] a, output int v);
    @(negedge clk); addr = a; #1 v = int'(rdata);
    @(negedge clk); addr = 4'h8;
  endtask

  function automatic logic [31:0] cw(input bit run, input bit rsten, input bit irqen,
                                     input int dsel, input int pre);
    return 32'((pre << 8) | (dsel << 4) | (irqen << 2) | (rsten << 1) | run);
  endfunction

  task automatic wait_irq(output int n);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!irq_o && n < 5000);
  endtask

  task automatic setup(input bit rsten, input bit irqen, input int dsel,
                       input int pre, input int rel);
    bus_wr(4'h0, cw(0, 0, 0, dsel, pre));
    bus_wr(4'h4, 32'(rel));
    bus_wr(4'h8, 32'(rel));
    bus_wr(4'h0, cw(1, rsten, irqen, dsel, pre));
  endtask

  task automatic summary();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000 && !done) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
    summary();
  end

  initial begin
    int v, n, k, base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_rd(4'h0, v); chk(v == 'hFF03, "R1", "ctrl", v, 'hFF03);
    bus_rd(4'h4, v); chk(v == 'h8000, "R1", "reload", v, 'h8000);
    bus_rd(4'h8, v); chk(v == 'h8000, "R1", "count", v, 'h8000);
    chk(!rst_o && !irq_o, "R1", "outputs", int'({rst_o, irq_o}), 0);

    // R2 unmapped offset
    bus_wr(4'hC, 32'hFFFF_FFFF);
    bus_rd(4'hC, v); chk(v == 0, "R2", "unmapped read", v, 0);
    bus_rd(4'h4, v); chk(v == 'h8000, "R2", "reload untouched", v, 'h8000);

    // R3 tick periods for several prescale / divider pairs
    setup(0, 1, 1, 1, 2);
    wait_irq(n); wait_irq(n);
    chk(n == 2 * 32 * 3, "R3", "gap p1 /32 r2", n, 192);
    setup(0, 1, 3, 0, 1);
    wait_irq(n); wait_irq(n);
    chk(n == 128 * 2, "R3", "gap p0 /128 r1", n, 256);
    setup(0, 1, 0, 2, 3);
    wait_irq(n); wait_irq(n);
    chk(n == 3 * 16 * 4, "R3", "gap p2 /16 r3", n, 192);

    // R7 write of zero: expiry one full scaled period later
    bus_wr(4'h8, 32'h0);
    wait_irq(n);
    chk(n == 48, "R7", "restart period", n, 48);
    // R7 keep-alive prevents expiry
    base = irq_total;
    for (int i = 0; i < 12; i++) begin
      repeat (60) @(negedge clk);
      bus_wr(4'h8, 32'h3);
    end
    chk(irq_total == base, "R7", "no expiry under keep-alive", irq_total, base);

    // R8 reload change does not disturb live count
    bus_rd(4'h8, k);
    bus_wr(4'h4, 32'h7);
    bus_rd(4'h8, v); chk(v == k, "R8", "count after reload write", v, k);
    wait_irq(n);
    bus_rd(4'h8, v); chk(v == 7, "R8", "count after expiry", v, 7);

    // R9 halt keeps state and stops expiry
    bus_wr(4'h0, cw(0, 0, 1, 0, 2));
    bus_rd(4'h8, k);
    base = irq_total;
    repeat (500) @(negedge clk);
    bus_rd(4'h8, v); chk(v == k, "R9", "count held", v, k);
    bus_rd(4'h4, v); chk(v == 7, "R9", "reload kept", v, 7);
    chk(irq_total == base, "R9", "no expiry while halted", irq_total, base);

    // R6 reset only: pulse length, no interrupt
    setup(1, 0, 0, 0, 1);
    base = irq_total;
    n = 0;
    while (!rst_o && n < 2000) begin @(posedge clk); #1; n++; end
    k = 0;
    while (rst_o && k < 100) begin @(posedge clk); #1; k++; end
    chk(k == RLEN, "R6", "reset pulse length", k, RLEN);
    chk(irq_total == base, "R6", "no irq with irq disabled", irq_total, base);

    // R10 both enables
    setup(1, 1, 0, 0, 1);
    wait_irq(n);
    chk(rst_o == 1'b1, "R10", "reset with irq", int'(rst_o), 1);
    @(posedge clk); #1;
    chk(!irq_o && rst_o, "R10", "irq single cycle, reset held",
        int'({irq_o, rst_o}), 1);

    repeat (20) @(negedge clk);
    summary();
  end

endmodule